// File: doc/BRIEF.md
# Presettable Synchronous Binary Counter

This block is an up counter built from one or more four-bit slices. Every state bit is updated on the same rising clock edge. There is no ripple from one bit to the next. A parallel value can be loaded on a clock edge, and two enable inputs must both be high for the counter to advance. A carry output lets several instances, or several internal slices, be chained into a wider counter that stays synchronous. No extra gating is needed for the chain.

Control follows a fixed priority: clear, then load, then count, then hold. A parameter chooses one of two clear styles. With the asynchronous style, the clear zeroes the count at once. With the synchronous style, the clear acts at the next clock edge. The synchronous style can give a modulo-N counter: an outside decode of the count N-1 drives the clear input, so the sequence runs from 0 to N-1.

Inside the block, the carry of each slice drives the carry-gating enable of the next slice. All slices share the count-gating enable, the load and the clear. The top-level carry output is high only when the carry-gating enable is high and every bit of the count is one.

Top module: `preset_counter`

## Requirements
- R1: With ASYNC_CLEAR=1, a low on clr_n drives q to zero at once, without waiting for a clock edge, whatever the levels of load_n, enp and ent.
- R2: With ASYNC_CLEAR=0, a low on clr_n leaves q unchanged until the next rising edge, and q is zero after that edge, whatever the levels of load_n, enp and ent.
- R3: When clr_n is high and load_n is low at a rising edge, q takes the value of d, whatever the levels of enp and ent.
- R4: When clr_n and load_n are high at a rising edge, q increments by one only if enp and ent are both high. Otherwise q holds. Changes on enp, ent or load_n between edges do not alter q.
- R5: When counting, a count of all ones wraps to all zeros.
- R6: rco is high exactly when ent is high and every bit of q is one. It follows ent with no clock delay.
- R7: Priority at an edge is clear, then load, then count, then hold. A clear overrides a load, and a load overrides a count.
- R8: With NUM_SLICES slices, q behaves as one counter of SLICE_W*NUM_SLICES bits. An upper slice advances only when all lower slices hold all ones. The chained rco is high only when the full count is all ones and ent is high.
- R9: The sequence clear, preset to 12, then count, gives 13, 14, 15, 0, 1, 2. Dropping either enable after that holds 2.
- R10: With ASYNC_CLEAR=0 and clr_n driven low while q equals 9, continuous counting gives the repeating sequence 0 through 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all state bits |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous per ASYNC_CLEAR |
| load_n | input | 1 | Active-low synchronous parallel load |
| enp | input | 1 | Count enable that does not gate the carry |
| ent | input | 1 | Count enable that also gates rco |
| d | input | SLICE_W*NUM_SLICES | Parallel load value |
| q | output | SLICE_W*NUM_SLICES | Current count |
| rco | output | 1 | Carry out: ent high and q all ones |

## Verification
The bench runs the same stimulus on an asynchronous-clear instance and a synchronous-clear instance. It drops the clear in the middle of a cycle. A design with the wrong clear style would zero the synchronous instance too early, or would leave the asynchronous instance unchanged until the edge. Load requests placed against active enables, and clears placed against loads, show up a wrong priority order as a loaded or counted value where zero or d was expected. The bench checks rco with ent toggling while the count is all ones, and after a wrap. A registered or ungated carry would show a stale high there. A three-slice chain is taken across slice boundaries (0x0FF to 0x100, and 0xFFF to 0x000). A modulo-10 loop is closed through the synchronous clear. An off-by-one in the carry chain, or a clear that acts at once, would break those sequences.

// File: rtl/cnt_pkg.sv
// Package: shared types for the presettable counter.
// Assumes: nothing beyond standard SystemVerilog.
package cnt_pkg;

    // Operation chosen for a slice at the coming clock edge.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } cnt_op_e;

endpackage

// File: rtl/cnt_op_decode.sv
// Module: cnt_op_decode
// Picks the operation for the next clock edge, using the fixed priority
// clear > load > count > hold.
// Assumes: in the asynchronous-clear variant the flops handle the clear
// themselves, so clr_n is not decoded here.
module cnt_op_decode #(
    parameter bit SYNC_CLEAR = 1'b0
) (
    input  logic            clr_n,
    input  logic            load_n,
    input  logic            enp,
    input  logic            ent,
    output cnt_pkg::cnt_op_e op
);
    import cnt_pkg::*;

    logic clr_req;

    // Clear request exists only in the synchronous variant.
    generate
        if (SYNC_CLEAR) begin : g_sync_clr
            assign clr_req = ~clr_n;
        end else begin : g_no_clr
            assign clr_req = 1'b0;
        end
    endgenerate

    // Priority encode the control inputs into a single operation.
    always_comb begin
        if (clr_req)            op = OP_CLEAR;
        else if (!load_n)       op = OP_LOAD;
        else if (enp && ent)    op = OP_COUNT;
        else                    op = OP_HOLD;
    end

endmodule

// File: rtl/cnt_slice.sv
// Module: cnt_slice
// One counter slice of W bits. It works out the next state from the
// decoded operation, stores it on the rising edge, and drives a carry that
// is high when the carry enable is high and the slice is all ones.
// Assumes: clr_n is the only reset; ASYNC_CLEAR chooses whether it acts
// at once or at the edge.
module cnt_slice #(
    parameter int W           = 4,
    parameter bit ASYNC_CLEAR = 1'b1
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         load_n,
    input  logic         enp,
    input  logic         ent,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         rco
);
    import cnt_pkg::*;

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    cnt_op_e      op;
    logic [W-1:0] nxt;

    cnt_op_decode #(.SYNC_CLEAR(!ASYNC_CLEAR)) u_dec (
        .clr_n  (clr_n),
        .load_n (load_n),
        .enp    (enp),
        .ent    (ent),
        .op     (op)
    );

    // Next-state value for the selected operation; the increment wraps.
    always_comb begin
        case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = d;
            OP_COUNT: nxt = q + ONE;
            default:  nxt = q;
        endcase
    end

    // State register in the chosen clear style.
    generate
        if (ASYNC_CLEAR) begin : g_async
            // Asynchronous clear wins over the clock.
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) q <= '0;
                else        q <= nxt;
            end
        end else begin : g_sync
            // Synchronous clear is already folded into nxt.
            always_ff @(posedge clk) begin
                q <= nxt;
            end
        end
    endgenerate

    // Terminal-count carry, gated only by the carry enable.
    assign rco = ent & (&q);

endmodule

// File: rtl/preset_counter.sv
// Module: preset_counter (top)
// A chain of NUM_SLICES counter slices that acts as one synchronous
// counter. Each slice's carry drives the next slice's carry enable. Load,
// clear and the count enable enp go to every slice.
// Assumes: one clock for all slices; d is sampled only at load edges.
module preset_counter #(
    parameter int SLICE_W     = 4,
    parameter int NUM_SLICES  = 1,
    parameter bit ASYNC_CLEAR = 1'b1,
    localparam int TOTAL_W    = SLICE_W * NUM_SLICES
) (
    input  logic               clk,
    input  logic               clr_n,
    input  logic               load_n,
    input  logic               enp,
    input  logic               ent,
    input  logic [TOTAL_W-1:0] d,
    output logic [TOTAL_W-1:0] q,
    output logic               rco
);

    logic [NUM_SLICES:0] carry;

    // The lowest slice takes the external carry enable.
    assign carry[0] = ent;

    // Build the chain; slice k's carry enables slice k+1.
    generate
        for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
            cnt_slice #(
                .W           (SLICE_W),
                .ASYNC_CLEAR (ASYNC_CLEAR)
            ) u_slice (
                .clk    (clk),
                .clr_n  (clr_n),
                .load_n (load_n),
                .enp    (enp),
                .ent    (carry[k]),
                .d      (d[k*SLICE_W +: SLICE_W]),
                .q      (q[k*SLICE_W +: SLICE_W]),
                .rco    (carry[k+1])
            );
        end
    endgenerate

    // The carry of the top slice is the carry of the whole chain.
    assign rco = carry[NUM_SLICES];

endmodule

// File: rtl/preset_counter_chk.sv
// Module: preset_counter_chk
// Checker bound to preset_counter. It relates the control inputs to the
// count and the carry over time.
// Assumes: clr_n is held low for at least one edge before checks start.
module preset_counter_chk #(
    parameter int TOTAL_W     = 4,
    parameter bit ASYNC_CLEAR = 1'b1
) (
    input logic               clk,
    input logic               clr_n,
    input logic               load_n,
    input logic               enp,
    input logic               ent,
    input logic [TOTAL_W-1:0] d,
    input logic [TOTAL_W-1:0] q,
    input logic               rco
);
    localparam logic [TOTAL_W-1:0] ONE = {{(TOTAL_W-1){1'b0}}, 1'b1};

    logic armed;

    // Becomes one after the first edge seen with the clear low.
    always_ff @(posedge clk) begin
        if (!clr_n) armed <= 1'b1;
    end

    // R3 and R7: a load without a clear takes d at the edge.
    a_r3_load_takes_d: assert property (@(posedge clk)
        disable iff (!clr_n || armed !== 1'b1)
        !load_n |=> q == $past(d));

    // R4 and R5: counting adds one, with wrap.
    a_r4_count_step: assert property (@(posedge clk)
        disable iff (!clr_n || armed !== 1'b1)
        (load_n && enp && ent) |=> q == $past(q) + ONE);

    // R4: with either enable low and no load, the count holds.
    a_r4_hold: assert property (@(posedge clk)
        disable iff (!clr_n || armed !== 1'b1)
        (load_n && !(enp && ent)) |=> $stable(q));

    // R6 and R8: the carry tracks ent and a full count of ones.
    a_r6_rco_terminal: assert property (@(posedge clk)
        disable iff (armed !== 1'b1)
        rco == (ent && (q == {TOTAL_W{1'b1}})));

    generate
        if (ASYNC_CLEAR) begin : g_chk_async
            // R1: a low clear has already zeroed the count.
            a_r1_async_zero: assert property (@(posedge clk)
                disable iff (armed !== 1'b1)
                !clr_n |-> q == '0);
        end else begin : g_chk_sync
            // R2 and R7: a low clear zeroes the count at the next edge.
            a_r2_sync_zero: assert property (@(posedge clk)
                disable iff (armed !== 1'b1)
                !clr_n |=> q == '0);
        end
    endgenerate

endmodule

bind preset_counter preset_counter_chk #(
    .TOTAL_W     (TOTAL_W),
    .ASYNC_CLEAR (ASYNC_CLEAR)
) u_chk (
    .clk    (clk),
    .clr_n  (clr_n),
    .load_n (load_n),
    .enp    (enp),
    .ent    (ent),
    .d      (d),
    .q      (q),
    .rco    (rco)
);

// File: tb/tb_preset_counter.sv
`timescale 1ns/1ps
module tb_preset_counter;

    localparam int PERIOD = 8;

    logic clk = 1'b0;
    always #(PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Shared stimulus for the two single-slice instances.
    logic       clr_n, load_n, enp, ent, mod_en;
    logic [3:0] d;
    logic [3:0] q_a, q_s;
    logic       rco_a, rco_s;
    logic       s_clr_n;

    // Modulo-10 feedback for the synchronous instance (R10).
    assign s_clr_n = mod_en ? (q_s != 4'd9) : clr_n;

    preset_counter #(.SLICE_W(4), .NUM_SLICES(1), .ASYNC_CLEAR(1'b1)) dut (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .enp(enp), .ent(ent),
        .d(d), .q(q_a), .rco(rco_a));

    preset_counter #(.SLICE_W(4), .NUM_SLICES(1), .ASYNC_CLEAR(1'b0)) dut_s (
        .clk(clk), .clr_n(s_clr_n), .load_n(load_n), .enp(enp), .ent(ent),
        .d(d), .q(q_s), .rco(rco_s));

    // Three-slice chain (R8).
    logic        c_clr_n, c_load_n, c_enp, c_ent, c_rco;
    logic [11:0] c_d, c_q;

    preset_counter #(.SLICE_W(4), .NUM_SLICES(3), .ASYNC_CLEAR(1'b1)) dut_cas (
        .clk(clk), .clr_n(c_clr_n), .load_n(c_load_n), .enp(c_enp),
        .ent(c_ent), .d(c_d), .q(c_q), .rco(c_rco));

    // Vector: {req[3:0], clr_n, load_n, enp, ent, d[3:0], exp_q[3:0], exp_rco}
    localparam int NV = 16;
    localparam logic [16:0] VEC [NV] = '{
        {4'd9, 4'b0111, 4'd0,  4'd0,  1'b0},  // R9 clear
        {4'd9, 4'b1000, 4'd12, 4'd12, 1'b0},  // R9 preset twelve
        {4'd9, 4'b1111, 4'd0,  4'd13, 1'b0},  // R9 count
        {4'd9, 4'b1111, 4'd0,  4'd14, 1'b0},  // R9
        {4'd6, 4'b1111, 4'd0,  4'd15, 1'b1},  // R6 terminal with ent high
        {4'd5, 4'b1111, 4'd0,  4'd0,  1'b0},  // R5 wrap
        {4'd9, 4'b1111, 4'd0,  4'd1,  1'b0},  // R9
        {4'd9, 4'b1111, 4'd0,  4'd2,  1'b0},  // R9
        {4'd9, 4'b1101, 4'd0,  4'd2,  1'b0},  // R9 inhibit via enp
        {4'd4, 4'b1110, 4'd0,  4'd2,  1'b0},  // R4 inhibit via ent
        {4'd3, 4'b1001, 4'd15, 4'd15, 1'b1},  // R3 load with enp low
        {4'd4, 4'b1101, 4'd0,  4'd15, 1'b1},  // R4 hold, R6 carry stays
        {4'd6, 4'b1110, 4'd0,  4'd15, 1'b0},  // R6 ent low masks carry
        {4'd7, 4'b1011, 4'd5,  4'd5,  1'b0},  // R7 load beats count
        {4'd7, 4'b0011, 4'd9,  4'd0,  1'b0},  // R7 clear beats load
        {4'd4, 4'b1111, 4'd0,  4'd1,  1'b0}   // R4 count
    };

    task automatic chk(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Advance one edge and settle away from it.
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        clr_n = 1'b0; load_n = 1'b1; enp = 1'b0; ent = 1'b0; d = '0; mod_en = 1'b0;
        c_clr_n = 1'b0; c_load_n = 1'b1; c_enp = 1'b0; c_ent = 1'b0; c_d = '0;
        step(); step();
        // R1 R2 reset state
        chk(1, "reset q async", q_a, 0);
        chk(2, "reset q sync", q_s, 0);
        chk(8, "reset chain q", c_q, 0);
        chk(6, "reset rco", rco_a, 0);

        // Table walk over both single-slice instances.
        for (int i = 0; i < NV; i++) begin
            logic [16:0] v;
            v = VEC[i];
            {clr_n, load_n, enp, ent} = v[12:9];
            d = v[8:5];
            step();
            chk(int'(v[16:13]), $sformatf("vec%0d q async", i), q_a, v[4:1]);
            chk(int'(v[16:13]), $sformatf("vec%0d rco async", i), rco_a, v[0]);
            chk(int'(v[16:13]), $sformatf("vec%0d q sync", i), q_s, v[4:1]);
            chk(int'(v[16:13]), $sformatf("vec%0d rco sync", i), rco_s, v[0]);
        end

        // R4: a load request between edges does not alter q.
        clr_n = 1'b1; load_n = 1'b0; enp = 1'b0; ent = 1'b0; d = 4'd7;
        #1;
        chk(4, "no change before edge", q_a, 1);
        step();
        chk(3, "load 7", q_a, 7);
        load_n = 1'b1;

        // R1 / R2: clear dropped mid-cycle.
        clr_n = 1'b0;
        #1;
        chk(1, "async clear immediate", q_a, 0);
        chk(2, "sync clear waits for edge", q_s, 7);
        step();
        chk(2, "sync clear at edge", q_s, 0);
        clr_n = 1'b1;

        // R10: modulo-10 through the synchronous clear.
        enp = 1'b1; ent = 1'b1; mod_en = 1'b1;
        for (int i = 1; i <= 12; i++) begin
            step();
            chk(10, $sformatf("mod10 step %0d", i), q_s, i % 10);
            chk(5, $sformatf("free run step %0d", i), q_a, i % 16);
        end
        mod_en = 1'b0;

        // R8: three-slice chain across slice boundaries.
        c_clr_n = 1'b1; c_load_n = 1'b0; c_d = 12'h0FE; c_enp = 1'b1; c_ent = 1'b1;
        step();
        chk(8, "chain load", c_q, 12'h0FE);
        c_load_n = 1'b1;
        step();
        chk(8, "chain 0FF", c_q, 12'h0FF);
        chk(8, "chain rco partial", c_rco, 0);
        step();
        chk(8, "chain carry into slice 2", c_q, 12'h100);
        c_enp = 1'b0;
        step();
        chk(8, "chain hold enp low", c_q, 12'h100);
        c_enp = 1'b1; c_load_n = 1'b0; c_d = 12'hFFE;
        step();
        c_load_n = 1'b1;
        step();
        chk(8, "chain FFF", c_q, 12'hFFF);
        chk(8, "chain rco full", c_rco, 1);
        c_ent = 1'b0;
        #1;
        chk(6, "chain rco follows ent", c_rco, 0);
        step();
        chk(8, "chain hold ent low", c_q, 12'hFFF);
        c_ent = 1'b1;
        step();
        chk(8, "chain wrap", c_q, 12'h000);
        chk(8, "chain rco after wrap", c_rco, 0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule